// File: doc/BRIEF.md
# Shared-Map Display Column Bus Slave

This block is the host-facing slave of one display column driver that is one of up to four identical drivers sharing a single flat 17-bit address space. Two position straps tell the block which quadrant of the combined panel it owns. It then claims only the display bytes of that quadrant and only its own bank of sixteen gray-level palette entries. The host may use an 8-bit or a 16-bit little-endian data bus. A 16-bit bus can carry byte or word transfers.

The display memory is modelled as a single-port RAM split into an even-byte bank and an odd-byte bank. The display side pulls one line at a time out of that RAM as a valid/ready stream of 16-bit beats. Each beat holds four packed 4-bit pixels. Each pixel is also translated through the palette into a 6-bit level. A line fetch owns the RAM port from its start until its last beat is taken. During that time a host RAM access is held off by a low ready. The access is then served, never dropped. Palette accesses do not touch the RAM and are answered at once. Back-pressure on the pixel stream follows the usual rule: a beat advances only on a cycle with `pix_valid` and `pix_ready` both high, and `pix_data` holds while `pix_ready` is low. Because the fetch holds the RAM port until its last beat, a stalled sink lengthens the host wait by the same number of cycles.

A host access is the cycle-level request `bus_sel` with exactly one of `bus_rd`/`bus_wr`. The host holds it until it sees `bus_rdy` high. The transfer takes effect at the clock edge where `bus_rdy_oe` and `bus_rdy` are both high. Read data is valid in that same cycle. The enable outputs stand for the tri-state drivers of a wired bus.

Top module: `lcd_col_bus_if`

## Requirements
- R1: With `bus_narrow` high the bus is 8 bits wide. Every address names one byte, carried on `bus_wdata[7:0]`/`bus_rdata[7:0]`. `bus_wdata[15:8]` and `bus_ube_n` are ignored, and `bus_rdata_oe[1]` stays low.
- R2: With `bus_narrow` low, lanes follow little-endian rules. An even address with `bus_ube_n` high moves only the low lane, to the even byte. An odd address with `bus_ube_n` low moves only the high lane, to the odd byte. An even address with `bus_ube_n` low moves a word: low lane to the even byte, high lane to the next byte. An odd address with `bus_ube_n` high is no access.
- R3: Pixels are 4 bits, two per byte, and the earlier pixel is in the low nibble. A fetch beat is `{odd byte, even byte}`. Pixel k of the beat is nibble k counted from bit 0, and its level is `pix_level[6k+5:6k]`.
- R4: Address bits 16..8 give the panel line and bits 7..0 give the byte in that line. Strap bit 0 set claims lines NUM_LINES..2·NUM_LINES-1, otherwise lines 0..NUM_LINES-1. Strap bit 1 set claims bytes 120..239, otherwise bytes 0..119. Straps 00, 01, 10, 11 are positions 0, 1, 2, 3.
- R5: Position p owns the palette at even addresses 0x1FF80+0x20·p .. +0x1E, and gray code n sits at offset 2n. A write stores `bus_wdata[5:0]`. A read returns the entry on `bus_rdata[5:0]` with only the low lane enabled. Odd addresses and other positions' banks are not claimed.
- R6: Reset loads gray codes 0..15 with levels 0, 4, 8, 12, 16, 19, 21, 23, 25, 27, 29, 32, 36, 40, 44, 48.
- R7: A claimed RAM access made while a line fetch is active sees `bus_rdy` low until the fetch's last beat is taken. It is then performed, with no loss of write data, and a read returns the current contents.
- R8: A palette access never waits: `bus_rdy` is high in its first cycle even during a fetch.
- R9: When `bus_sel` is low, or the address falls outside this position's RAM slice and palette bank, `bus_rdy_oe` and both `bus_rdata_oe` bits are low.
- R10: A `line_fetch` pulse naming a local line starts a fetch of LINE_BYTES/2 beats, read in ascending byte order. The final beat carries `pix_last`. A pulse that arrives while a fetch is active is ignored.
- R11: Read data lanes are enabled only for a read, only for the lanes of that access, and only while `bus_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_strap | input | 2 | Chip position straps (bit 0 row half, bit 1 column half) |
| bus_narrow | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| bus_sel | input | 1 | Host chip select, active high |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 17 | Host byte address |
| bus_ube_n | input | 1 | Upper byte enable, active low |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, zero on undriven lanes |
| bus_rdata_oe | output | 2 | Per-lane read data drive enable |
| bus_rdy | output | 1 | Ready to host, high when served |
| bus_rdy_oe | output | 1 | Drive enable for the ready line |
| line_fetch | input | 1 | Pulse to start a line fetch |
| fetch_line | input | LINE_W | Local line number to fetch |
| pix_valid | output | 1 | Fetch beat valid |
| pix_ready | input | 1 | Display side accepts the beat |
| pix_last | output | 1 | Final beat of the line |
| pix_data | output | 16 | Four packed 4-bit pixels |
| pix_level | output | 24 | Palette level of each of the four pixels |

## Verification
The bench concentrates on lane steering. A design that swapped lanes, or that honoured `bus_ube_n` or the upper lane in 8-bit mode, would return the wrong half-word or a stray byte on reads that follow mixed byte and word writes. Slice edges are probed: column 119 against 120, the first line of the neighbouring row half, and palette banks and odd palette addresses of other positions. A design with an off-by-one boundary would claim an access or leave it unclaimed, and the ready and data enables show which. The collision case starts a fetch and then issues a host write to the line being fetched. A design that let the host win, dropped the write, or released the wait early would show a wrong first beat, a wrong read-back, or a wait outside the fetch length. Back-pressure is held on the first beat while a palette write lands, to catch a palette that waits or a beat that moves without `pix_ready`.

// File: rtl/lcdbus_pkg.sv
package lcdbus_pkg;

  localparam int ADDR_W      = 17;
  localparam int DATA_W      = 16;
  localparam int LEVEL_W     = 6;
  localparam int PAL_ENTRIES = 16;
  localparam int PIX_W       = 4;
  localparam int PIX_PER_BEAT = DATA_W / PIX_W;

  // Result of decoding one host access against this chip's slice.
  typedef struct packed {
    logic hit;      // access is claimed by this chip
    logic pal;      // claimed access targets the palette
    logic lane_lo;  // low data lane carries data
    logic lane_hi;  // high data lane carries data
    logic even_en;  // even-byte bank takes part
    logic odd_en;   // odd-byte bank takes part
    logic odd_hi;   // odd bank is fed from the high lane
  } dec_t;

  // Level loaded into each gray-code entry at reset.
  function automatic logic [LEVEL_W-1:0] reset_level(input int code);
    logic [LEVEL_W-1:0] lv;
    case (code)
      0: lv = 6'd0;   1: lv = 6'd4;   2: lv = 6'd8;   3: lv = 6'd12;
      4: lv = 6'd16;  5: lv = 6'd19;  6: lv = 6'd21;  7: lv = 6'd23;
      8: lv = 6'd25;  9: lv = 6'd27;  10: lv = 6'd29; 11: lv = 6'd32;
      12: lv = 6'd36; 13: lv = 6'd40; 14: lv = 6'd44; default: lv = 6'd48;
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/lcdbus_decode.sv
module lcdbus_decode
  import lcdbus_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int LINE_BYTES = 120,
  parameter int IDX_W      = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              narrow,
  input  logic              ube_n,
  input  logic [1:0]        pos,
  input  logic              access,
  output dec_t              dec,
  output logic [IDX_W-1:0]  bank_idx,
  output logic [3:0]        pal_idx
);
  localparam int HALF = LINE_BYTES / 2;

  logic [8:0] line_f, row_base, line_loc;
  logic [7:0] col_f, col_base, col_loc;
  logic       in_row, in_col, ram_hit, pal_hit, lanes_ok;
  logic       lo, hi, ev, od, ohi;

  assign line_f   = addr[16:8];
  assign col_f    = addr[7:0];
  assign row_base = pos[0] ? 9'(NUM_LINES) : 9'd0;
  assign col_base = pos[1] ? 8'(LINE_BYTES) : 8'd0;

  assign in_row = (line_f >= row_base) &&
                  ({1'b0, line_f} < ({1'b0, row_base} + 10'(NUM_LINES)));
  assign in_col = (col_f >= col_base) &&
                  ({1'b0, col_f} < ({1'b0, col_base} + 9'(LINE_BYTES)));
  assign ram_hit = in_row && in_col;

  assign line_loc = line_f - row_base;
  assign col_loc  = col_f - col_base;
  assign bank_idx = IDX_W'(32'(line_loc) * HALF + (32'(col_loc) >> 1));

  // Palette bank: top ten address bits all ones, bank field equals position.
  assign pal_hit = (&addr[16:7]) && (addr[6:5] == pos) && !addr[0];
  assign pal_idx = addr[4:1];

  always_comb begin
    lo = 1'b0; hi = 1'b0; ev = 1'b0; od = 1'b0; ohi = 1'b0; lanes_ok = 1'b1;
    if (narrow) begin
      lo = 1'b1;
      ev = !addr[0];
      od = addr[0];
    end else begin
      case ({addr[0], ube_n})
        2'b01: begin lo = 1'b1; ev = 1'b1; end
        2'b10: begin hi = 1'b1; od = 1'b1; ohi = 1'b1; end
        2'b00: begin lo = 1'b1; hi = 1'b1; ev = 1'b1; od = 1'b1; ohi = 1'b1; end
        default: lanes_ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    dec.hit     = access && lanes_ok && (ram_hit || pal_hit);
    dec.pal     = pal_hit;
    dec.lane_lo = lo;
    dec.lane_hi = pal_hit ? 1'b0 : hi;
    dec.even_en = ev;
    dec.odd_en  = od;
    dec.odd_hi  = ohi;
  end

endmodule

// File: rtl/lcdbus_bank.sv
module lcdbus_bank #(
  parameter int DEPTH = 1920,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wd,
  output logic [7:0]       rd
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
  end

  assign rd = mem[idx];

endmodule

// File: rtl/lcdbus_palette.sv
module lcdbus_palette
  import lcdbus_pkg::*;
#(
  parameter int NLOOK = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [3:0]                      idx,
  input  logic [LEVEL_W-1:0]              wd,
  output logic [LEVEL_W-1:0]              rd,
  input  logic [NLOOK-1:0][PIX_W-1:0]     lk_code,
  output logic [NLOOK-1:0][LEVEL_W-1:0]   lk_level
);
  logic [LEVEL_W-1:0] lvl_q [PAL_ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAL_ENTRIES; i++) lvl_q[i] <= reset_level(i);
    end else if (we) begin
      lvl_q[idx] <= wd;
    end
  end

  assign rd = lvl_q[idx];

  for (genvar k = 0; k < NLOOK; k++) begin : g_look
    assign lk_level[k] = lvl_q[lk_code[k]];
  end

endmodule

// File: rtl/lcdbus_fetch.sv
module lcdbus_fetch #(
  parameter int NUM_LINES = 32,
  parameter int BEATS     = 60,
  parameter int LINE_W    = 5,
  parameter int IDX_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINE_W-1:0] line,
  input  logic              ready,
  output logic              busy,
  output logic              last,
  output logic [IDX_W-1:0]  idx
);
  localparam int BEAT_W = $clog2(BEATS);

  logic              busy_q;
  logic [IDX_W-1:0]  base_q;
  logic [BEAT_W-1:0] beat_q;
  logic              start_ok;

  assign start_ok = start && !busy_q && (32'(line) < NUM_LINES);
  assign last     = busy_q && (beat_q == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
    end else if (start_ok) begin
      busy_q <= 1'b1;
      base_q <= IDX_W'(32'(line) * BEATS);
      beat_q <= '0;
    end else if (busy_q && ready) begin
      if (last) busy_q <= 1'b0;
      else      beat_q <= beat_q + 1'b1;
    end
  end

  assign busy = busy_q;
  assign idx  = base_q + IDX_W'(beat_q);

endmodule

// File: rtl/lcd_col_bus_if.sv
module lcd_col_bus_if
  import lcdbus_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int LINE_BYTES = 120,
  parameter int LINE_W     = $clog2(NUM_LINES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [1:0]                        pos_strap,
  input  logic                              bus_narrow,
  input  logic                              bus_sel,
  input  logic                              bus_rd,
  input  logic                              bus_wr,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              bus_ube_n,
  input  logic [DATA_W-1:0]                 bus_wdata,
  output logic [DATA_W-1:0]                 bus_rdata,
  output logic [1:0]                        bus_rdata_oe,
  output logic                              bus_rdy,
  output logic                              bus_rdy_oe,
  input  logic                              line_fetch,
  input  logic [LINE_W-1:0]                 fetch_line,
  output logic                              pix_valid,
  input  logic                              pix_ready,
  output logic                              pix_last,
  output logic [DATA_W-1:0]                 pix_data,
  output logic [PIX_PER_BEAT*LEVEL_W-1:0]   pix_level
);
  localparam int BEATS = LINE_BYTES / 2;
  localparam int DEPTH = NUM_LINES * BEATS;
  localparam int IDX_W = $clog2(DEPTH);

  dec_t             dec;
  logic [IDX_W-1:0] host_idx, fetch_idx, ram_idx;
  logic [3:0]       pal_idx;
  logic             access, fire, fetch_busy;
  logic             even_we, odd_we, pal_we;
  logic [7:0]       even_wd, odd_wd, even_q, odd_q;
  logic [LEVEL_W-1:0] pal_rd;
  logic [PIX_PER_BEAT-1:0][PIX_W-1:0]   codes;
  logic [PIX_PER_BEAT-1:0][LEVEL_W-1:0] levels;

  assign access = bus_sel && (bus_rd ^ bus_wr);

  lcdbus_decode #(
    .NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .narrow(bus_narrow), .ube_n(bus_ube_n), .pos(pos_strap),
    .access(access), .dec(dec), .bank_idx(host_idx), .pal_idx(pal_idx)
  );

  lcdbus_fetch #(
    .NUM_LINES(NUM_LINES), .BEATS(BEATS), .LINE_W(LINE_W), .IDX_W(IDX_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(line_fetch), .line(fetch_line),
    .ready(pix_ready), .busy(fetch_busy), .last(pix_last), .idx(fetch_idx)
  );

  // Ready: palette always, RAM only when the display side does not own it.
  assign bus_rdy_oe = dec.hit;
  assign bus_rdy    = dec.hit && (dec.pal || !fetch_busy);
  assign fire       = bus_rdy;

  // Single RAM port: the line fetch has fixed priority.
  assign ram_idx = fetch_busy ? fetch_idx : host_idx;
  assign even_we = fire && bus_wr && !dec.pal && dec.even_en;
  assign odd_we  = fire && bus_wr && !dec.pal && dec.odd_en;
  assign even_wd = bus_wdata[7:0];
  assign odd_wd  = dec.odd_hi ? bus_wdata[15:8] : bus_wdata[7:0];
  assign pal_we  = fire && bus_wr && dec.pal;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic       b_we;
    logic [7:0] b_wd, b_rd;
    assign b_we = (b == 0) ? even_we : odd_we;
    assign b_wd = (b == 0) ? even_wd : odd_wd;
    lcdbus_bank #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .we(b_we), .idx(ram_idx), .wd(b_wd), .rd(b_rd)
    );
  end
  assign even_q = g_bank[0].b_rd;
  assign odd_q  = g_bank[1].b_rd;

  lcdbus_palette #(.NLOOK(PIX_PER_BEAT)) u_pal (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .idx(pal_idx),
    .wd(bus_wdata[LEVEL_W-1:0]), .rd(pal_rd),
    .lk_code(codes), .lk_level(levels)
  );

  // Host read lane steering.
  always_comb begin
    bus_rdata    = '0;
    bus_rdata_oe = '0;
    if (fire && bus_rd) begin
      if (dec.pal) begin
        bus_rdata[LEVEL_W-1:0] = pal_rd;
        bus_rdata_oe           = 2'b01;
      end else begin
        if (dec.lane_lo) bus_rdata[7:0]  = dec.even_en ? even_q : odd_q;
        if (dec.lane_hi) bus_rdata[15:8] = odd_q;
        bus_rdata_oe = {dec.lane_hi, dec.lane_lo};
      end
    end
  end

  // Display stream.
  assign pix_valid = fetch_busy;
  assign pix_data  = fetch_busy ? {odd_q, even_q} : '0;
  for (genvar k = 0; k < PIX_PER_BEAT; k++) begin : g_pix
    assign codes[k] = pix_data[k*PIX_W +: PIX_W];
    assign pix_level[k*LEVEL_W +: LEVEL_W] = levels[k];
  end

endmodule

// File: rtl/lcd_col_bus_if_chk.sv
module lcd_col_bus_if_chk #(
  parameter int BEATS = 60
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_rd,
  input logic        bus_narrow,
  input logic [1:0]  bus_rdata_oe,
  input logic        bus_rdy,
  input logic        bus_rdy_oe,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic        pix_last,
  input logic [15:0] pix_data
);
  logic [15:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     seen <= '0;
    else if (pix_valid && pix_ready) seen <= pix_last ? 16'd0 : seen + 16'd1;
  end

  AST_WAIT_ONLY_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdy_oe && !bus_rdy) |-> pix_valid); // R7
  AST_UNSEL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (!bus_rdy_oe && bus_rdata_oe == 2'b00)); // R9
  AST_NARROW_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_narrow |-> !bus_rdata_oe[1]); // R1
  AST_DATA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata_oe != 2'b00) |-> (bus_rdy && bus_rdy_oe && bus_rd)); // R11
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data))); // R10
  AST_LINE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && pix_last) |-> (seen == 16'(BEATS - 1))); // R10
  AST_NO_EARLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && !pix_last) |-> (seen < 16'(BEATS - 1))); // R10

endmodule

bind lcd_col_bus_if lcd_col_bus_if_chk #(.BEATS(LINE_BYTES / 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
  .bus_narrow(bus_narrow), .bus_rdata_oe(bus_rdata_oe), .bus_rdy(bus_rdy),
  .bus_rdy_oe(bus_rdy_oe), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_last(pix_last), .pix_data(pix_data)
);

// File: tb/lcd_col_bus_if_tb.sv
module lcd_col_bus_if_tb;
  localparam int NUM_LINES = 32;
  localparam int LINE_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pos_strap = 2'b00;
  logic bus_narrow = 1'b0, bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_ube_n = 1'b1;
  logic [16:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [1:0] bus_rdata_oe;
  logic bus_rdy, bus_rdy_oe;
  logic line_fetch = 1'b0, pix_ready = 1'b0, pix_valid, pix_last;
  logic [LINE_W-1:0] fetch_line = '0;
  logic [15:0] pix_data;
  logic [23:0] pix_level;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lcd_col_bus_if #(.NUM_LINES(NUM_LINES), .LINE_BYTES(120)) u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic do_acc(input logic nar, input logic wr, input logic [16:0] a, input logic ube,
                        input logic [15:0] wd, output logic hit, output logic [15:0] rd,
                        output logic [1:0] oe, output int waits);
    @(negedge clk);
    bus_narrow = nar; bus_sel = 1'b1; bus_wr = wr; bus_rd = !wr;
    bus_addr = a; bus_ube_n = ube; bus_wdata = wd;
    waits = 0;
    #1;
    hit = bus_rdy_oe;
    rd = bus_rdata; oe = bus_rdata_oe;
    if (hit) begin
      while (!bus_rdy && waits < 500) begin
        @(negedge clk); #1; waits++;
      end
      rd = bus_rdata; oe = bus_rdata_oe;
      @(posedge clk);
    end
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        nar;
    logic        wr;
    logic [16:0] addr;
    logic        ube;
    logic [15:0] wd;
    logic        hit;
    logic [15:0] exp;
    logic [1:0]  oe;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 1'b0, 1'b1, 17'h00000, 1'b0, 16'hA5C3, 1'b1, 16'h0000, 2'b00}, // R2 word write
    '{4'd2, 1'b0, 1'b0, 17'h00000, 1'b0, 16'h0000, 1'b1, 16'hA5C3, 2'b11}, // R2 word read
    '{4'd2, 1'b0, 1'b1, 17'h00102, 1'b1, 16'hFF11, 1'b1, 16'h0000, 2'b00}, // R2 low byte write
    '{4'd2, 1'b0, 1'b1, 17'h00103, 1'b0, 16'h2299, 1'b1, 16'h0000, 2'b00}, // R2 high byte write
    '{4'd2, 1'b0, 1'b0, 17'h00102, 1'b0, 16'h0000, 1'b1, 16'h2211, 2'b11}, // R2 word read back
    '{4'd11, 1'b0, 1'b0, 17'h00102, 1'b1, 16'h0000, 1'b1, 16'h0011, 2'b01}, // R11 low lane only
    '{4'd11, 1'b0, 1'b0, 17'h00103, 1'b0, 16'h0000, 1'b1, 16'h2200, 2'b10}, // R11 high lane only
    '{4'd1, 1'b1, 1'b1, 17'h00205, 1'b0, 16'hEE77, 1'b1, 16'h0000, 2'b00}, // R1 narrow odd write
    '{4'd1, 1'b1, 1'b1, 17'h00204, 1'b1, 16'h0044, 1'b1, 16'h0000, 2'b00}, // R1 narrow even write
    '{4'd1, 1'b0, 1'b0, 17'h00204, 1'b0, 16'h0000, 1'b1, 16'h7744, 2'b11}, // R1 upper lane ignored
    '{4'd1, 1'b1, 1'b0, 17'h00205, 1'b0, 16'h0000, 1'b1, 16'h0077, 2'b01}, // R1 narrow read
    '{4'd4, 1'b0, 1'b1, 17'h00076, 1'b0, 16'hBEEF, 1'b1, 16'h0000, 2'b00}, // R4 last word of slice
    '{4'd4, 1'b0, 1'b0, 17'h00076, 1'b0, 16'h0000, 1'b1, 16'hBEEF, 2'b11}, // R4 read back
    '{4'd9, 1'b0, 1'b0, 17'h00078, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'b00}, // R9 byte 120 not ours
    '{4'd9, 1'b0, 1'b0, 17'h02000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'b00}, // R9 line 32 not ours
    '{4'd2, 1'b0, 1'b0, 17'h00103, 1'b1, 16'h0000, 1'b0, 16'h0000, 2'b00}, // R2 odd with ube high
    '{4'd6, 1'b0, 1'b0, 17'h1FF80, 1'b0, 16'h0000, 1'b1, 16'h0000, 2'b01}, // R6 code 0
    '{4'd6, 1'b0, 1'b0, 17'h1FF96, 1'b0, 16'h0000, 1'b1, 16'h0020, 2'b01}, // R6 code 11
    '{4'd6, 1'b0, 1'b0, 17'h1FF9E, 1'b0, 16'h0000, 1'b1, 16'h0030, 2'b01}, // R6 code 15
    '{4'd6, 1'b0, 1'b0, 17'h1FF8A, 1'b0, 16'h0000, 1'b1, 16'h0013, 2'b01}, // R6 code 5
    '{4'd5, 1'b0, 1'b1, 17'h1FF84, 1'b0, 16'hFFC9, 1'b1, 16'h0000, 2'b00}, // R5 write D5..D0
    '{4'd5, 1'b0, 1'b0, 17'h1FF84, 1'b0, 16'h0000, 1'b1, 16'h0009, 2'b01}, // R5 read back
    '{4'd5, 1'b0, 1'b0, 17'h1FFA0, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'b00}, // R5 other bank
    '{4'd5, 1'b0, 1'b1, 17'h1FF84, 1'b0, 16'h0008, 1'b1, 16'h0000, 2'b00}, // R5 restore
    '{4'd5, 1'b1, 1'b0, 17'h1FF81, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'b00}  // R5 odd palette address
  };

  int beats = 0, last_at = 0;
  logic [15:0] beat1 = '0;
  always @(negedge clk) begin
    if (pix_valid && pix_ready) begin
      beats++;
      if (beats == 2) beat1 = pix_data;
      if (pix_last) last_at = beats;
    end
  end

  initial begin
    logic hit;
    logic [15:0] rd;
    logic [1:0] oe;
    int waits, wtot;

    repeat (3) @(negedge clk);
    // Reset state R9 R10
    check(!bus_rdy_oe && bus_rdata_oe == 2'b00, "R9 reset idle bus", {30'd0, bus_rdy_oe, bus_rdata_oe[0]}, 0);
    check(!pix_valid, "R10 reset no fetch", {31'd0, pix_valid}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      do_acc(v.nar, v.wr, v.addr, v.ube, v.wd, hit, rd, oe, waits);
      check(hit == v.hit, $sformatf("R%0d vec %0d claim", v.req, i), {31'd0, hit}, {31'd0, v.hit});
      if (v.hit && !v.wr) begin
        check(rd == v.exp, $sformatf("R%0d vec %0d data", v.req, i), {16'd0, rd}, {16'd0, v.exp});
        check(oe == v.oe, $sformatf("R%0d vec %0d lanes", v.req, i), {30'd0, oe}, {30'd0, v.oe});
      end
      if (!v.hit) check(oe == 2'b00, $sformatf("R9 vec %0d no drive", i), {30'd0, oe}, 0);
    end

    // R4 position 3: quadrant at line 32, byte 120
    pos_strap = 2'b11;
    do_acc(1'b0, 1'b1, 17'h02078, 1'b0, 16'h1357, hit, rd, oe, waits);
    check(hit, "R4 pos3 write claimed", {31'd0, hit}, 1);
    do_acc(1'b0, 1'b0, 17'h02078, 1'b0, 16'h0, hit, rd, oe, waits);
    check(rd == 16'h1357, "R4 pos3 read", {16'd0, rd}, 32'h1357);
    do_acc(1'b0, 1'b0, 17'h00000, 1'b0, 16'h0, hit, rd, oe, waits);
    check(!hit, "R4 pos3 ignores pos0 slice", {31'd0, hit}, 0);
    do_acc(1'b0, 1'b0, 17'h1FFE0, 1'b0, 16'h0, hit, rd, oe, waits);
    check(hit && rd == 16'h0000, "R5 pos3 palette bank", {15'd0, hit, rd}, 32'h10000);
    pos_strap = 2'b00;

    // Line 3 contents for the fetch
    do_acc(1'b0, 1'b1, 17'h00300, 1'b0, 16'h4321, hit, rd, oe, waits);
    do_acc(1'b0, 1'b1, 17'h00302, 1'b0, 16'h8765, hit, rd, oe, waits);

    @(negedge clk); line_fetch = 1'b1; fetch_line = 5'd3;
    @(negedge clk); line_fetch = 1'b0;
    check(pix_valid && pix_data == 16'h4321, "R10 first beat", {15'd0, pix_valid, pix_data}, 32'h14321);
    // pixels 1,2,3,4 -> levels 4,8,12,16, pixel 0 in low field
    check(pix_level == {6'd16, 6'd12, 6'd8, 6'd4}, "R3 pixel order and levels", {8'd0, pix_level}, {8'd0, 6'd16, 6'd12, 6'd8, 6'd4});
    // Palette write during fetch with back-pressure held
    do_acc(1'b0, 1'b1, 17'h1FF82, 1'b0, 16'h0005, hit, rd, oe, waits);
    check(hit && waits == 0, "R8 palette no wait", waits, 0);
    @(negedge clk);
    check(pix_valid && pix_data == 16'h4321, "R10 beat held", {15'd0, pix_valid, pix_data}, 32'h14321);
    check(pix_level[5:0] == 6'd5, "R3 level follows palette", {26'd0, pix_level[5:0]}, 5);
    do_acc(1'b0, 1'b1, 17'h1FF82, 1'b0, 16'h0004, hit, rd, oe, waits);

    fork
      begin
        @(negedge clk); pix_ready = 1'b1;
      end
      begin
        do_acc(1'b0, 1'b1, 17'h00300, 1'b0, 16'h9999, hit, rd, oe, wtot);
      end
      begin
        repeat (8) @(negedge clk);
        line_fetch = 1'b1; fetch_line = 5'd5;
        @(negedge clk); line_fetch = 1'b0;
      end
    join
    check(wtot >= 1 && wtot <= 62, "R7 host waited for fetch", wtot, 60);
    repeat (4) @(negedge clk);
    check(beats == 60 && last_at == 60, "R10 beat count and last", {beats[15:0], last_at[15:0]}, {16'd60, 16'd60});
    check(beat1 == 16'h8765, "R10 ascending beat order", {16'd0, beat1}, 32'h8765);
    check(!pix_valid, "R10 start while busy ignored", {31'd0, pix_valid}, 0);
    do_acc(1'b0, 1'b0, 17'h00300, 1'b0, 16'h0, hit, rd, oe, waits);
    check(rd == 16'h9999 && waits == 0, "R7 held write not lost", {16'd0, rd}, 32'h9999);

    finish_run();
  end

endmodule